// File: doc/BRIEF.md
# Clock-Control Register Slave on a Two-Wire Bus

This block is a target on a two-wire serial bus. It gives a bus master access to a bank of eight byte-wide control registers in a clock generator. The clock and data lines are sampled by the core clock. The block drives the data line only through an open-drain enable. Register contents are presented as one parallel vector to the clock logic. Some bits in that vector are read-only: three frequency-select straps captured after reset, and a fixed identity byte.

Each transfer starts with the 7-bit target address and a command code. If the command's top bit is set, the transfer is an indexed single-byte access. The low seven bits then give the register offset, and a repeated start turns the access into a read. If the top bit is clear, the transfer is a block access that starts at offset 0. On a block write the master sends a byte count and then the data bytes. On a block read the target returns a count of 8 and then the registers in ascending order, until the master answers with NACK.

Top module: `clkctl_smbus_slave`

## Requirements
- R1: After reset, register bytes 0..7 read FFh, F6h, FFh, 00h, 07h, 00h, {00011b, straps}, 28h. Byte k appears on regs_o[8k+7:8k]. The target does not drive the data line.
- R2: The target acknowledges only the 7-bit address 69h. Write frames use address byte D2h and read frames use D3h. A frame with any other address is not acknowledged and changes nothing.
- R3: In a byte write, the command byte has bit 7 = 1 and the offset in bits 6:0, and one data byte follows. The target acknowledges the address, the command and the data, and the data byte lands in that register.
- R4: A byte read is: command with bit 7 = 1, repeated start, address D3h, then one byte shifted out most significant bit first, then NACK.
- R5: A block write uses command 00h, then a byte count, then data bytes. The data bytes fill offsets 0, 1, 2… in order. A stop after any complete byte leaves the higher offsets unchanged.
- R6: A block read is: command 00h, repeated start, D3h. The target returns the count 08h first, then offsets 0 upward while the master acknowledges. A NACK ends the transfer.
- R7: These writes are acknowledged and ignored: byte 1 bit 3 (always reads 0), byte 6 bits 2:0, byte 7, and offsets above 7. Reads of offsets above 7 return 00h.
- R8: The three strap inputs are captured once, on the first clock after reset is released. Byte 6 bits 2:0 keep the captured value whatever the pins do later.
- R9: A START or STOP seen at any point aborts the frame in progress. A partly shifted data byte is never written.
- R10: The target changes its data-line drive only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Frequency-select straps, captured after reset |
| regs_o | output | 64 | Read view of register bytes 0..7 |

## Verification
The bench writes to a read-only identity byte, to a masked reserved bit and to an offset above the bank, then reads each back. A design that decoded only the low offset bits would alias offset 20h onto byte 0, and one that forgot a mask would show the written value. A block read checks that the leading count of 8 comes before offset 0. An off-by-one pointer would shift every byte by one place. The bench also aborts frames with a stop after four data bits and with a repeated start after the command. A design that wrote on partial bytes, or kept its old phase after a START, would corrupt a register.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int NUM_REGS  = 8;
  localparam int STRAP_REG = 6;
  localparam int ID_REG    = 7;
  localparam int STRAP_W   = 3;
  localparam logic [7:0] ID_BYTE = 8'h28;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_END, ST_ACK, ST_TX, ST_TX_ACK, ST_TX_NEXT
  } smb_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_COUNT, PH_WDATA
  } smb_phase_e;

  // writable bits per offset
  function automatic logic [7:0] reg_wmask(int idx);
    case (idx)
      1:       return 8'hF7;
      6:       return 8'hF8;
      7:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reg_rstval(int idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'hF6;
      2:       return 8'hFF;
      4:       return 8'h07;
      6:       return 8'h18;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import clkctl_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR  = 7'h69,
  parameter logic [7:0] BLK_COUNT = 8'(NUM_REGS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_s_i,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic [6:0] ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  localparam logic [6:0] PTR_MAX = '1;

  smb_state_e state_q;
  smb_phase_e phase_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] shreg_q, tx_q;
  logic [6:0] ptr_q;
  logic       is_read_q, cnt_pend_q, sda_oe_q;
  logic       ev_ok;
  logic [7:0] tx_byte;

  assign ev_ok     = !start_i && !stop_i;
  assign tx_byte   = cnt_pend_q ? BLK_COUNT : rd_data_i;
  assign wr_en_o   = (state_q == ST_RX_END) && scl_fall_i && ev_ok && (phase_q == PH_WDATA);
  assign wr_data_o = shreg_q;
  assign ptr_o     = ptr_q;
  assign sda_oe_o  = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_ADDR;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      is_read_q  <= 1'b0;
      cnt_pend_q <= 1'b0;
      sda_oe_q   <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_RX;
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      case (state_q)
        ST_RX: if (scl_rise_i) begin
          shreg_q   <= {shreg_q[6:0], sda_s_i};
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) state_q <= ST_RX_END;
        end
        ST_RX_END: if (scl_fall_i) begin
          state_q   <= ST_ACK;
          sda_oe_q  <= 1'b1;
          bit_cnt_q <= '0;
          case (phase_q)
            PH_ADDR: begin
              if (shreg_q[7:1] == SLV_ADDR) begin
                is_read_q <= shreg_q[0];
                phase_q   <= PH_CMD;
              end else begin
                state_q  <= ST_IDLE;
                sda_oe_q <= 1'b0;
              end
            end
            PH_CMD: begin
              cnt_pend_q <= ~shreg_q[7];
              ptr_q      <= shreg_q[7] ? shreg_q[6:0] : 7'd0;
              phase_q    <= shreg_q[7] ? PH_WDATA : PH_COUNT;
            end
            PH_COUNT: phase_q <= PH_WDATA;
            default:  if (ptr_q != PTR_MAX) ptr_q <= ptr_q + 7'd1;
          endcase
        end
        ST_ACK: if (scl_fall_i) begin
          if (is_read_q) begin
            tx_q      <= tx_byte;
            sda_oe_q  <= ~tx_byte[7];
            bit_cnt_q <= '0;
            state_q   <= ST_TX;
            if (cnt_pend_q) cnt_pend_q <= 1'b0;
            else if (ptr_q != PTR_MAX) ptr_q <= ptr_q + 7'd1;
          end else begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_RX;
          end
        end
        ST_TX: if (scl_fall_i) begin
          if (bit_cnt_q == 3'd7) begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_TX_ACK;
          end else begin
            sda_oe_q  <= ~tx_q[6];
            tx_q      <= {tx_q[6:0], 1'b0};
            bit_cnt_q <= bit_cnt_q + 3'd1;
          end
        end
        ST_TX_ACK: if (scl_rise_i) state_q <= sda_s_i ? ST_IDLE : ST_TX_NEXT;
        ST_TX_NEXT: if (scl_fall_i) begin
          tx_q      <= tx_byte;
          sda_oe_q  <= ~tx_byte[7];
          bit_cnt_q <= '0;
          state_q   <= ST_TX;
          if (cnt_pend_q) cnt_pend_q <= 1'b0;
          else if (ptr_q != PTR_MAX) ptr_q <= ptr_q + 7'd1;
        end
        default: ;
      endcase
    end
  end

  a_r10_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_q != $past(sda_oe_q)) && !$past(start_i || stop_i) |-> !$past(scl_s_i));

  a_r2_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_q);

  a_r5_block_from_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX_END) && scl_fall_i && ev_ok && (phase_q == PH_CMD) && !shreg_q[7]
    |=> (ptr_q == 7'd0));

  a_r4_tx_bit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX) && scl_s_i && $past(scl_s_i) |-> $stable(sda_oe_q));

  a_r9_stop_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE) && !sda_oe_q);
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [STRAP_W-1:0]    strap_i,
  input  logic                  wr_en_i,
  input  logic [6:0]            wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [6:0]            rd_addr_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int AW = $clog2(NUM_REGS);

  logic [STRAP_W-1:0] strap_q;
  logic               strap_vld_q;
  logic [7:0]         stored [NUM_REGS];
  logic [7:0]         rd_vec [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q     <= '0;
      strap_vld_q <= 1'b0;
    end else if (!strap_vld_q) begin
      strap_q     <= strap_i;
      strap_vld_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (reg_wmask(g) != 8'h00) begin : g_rw
      localparam logic [7:0] WM = reg_wmask(g);
      localparam logic [7:0] RV = reg_rstval(g) & WM;
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RV;
        else if (wr_en_i && (wr_addr_i == 7'(g))) q <= (q & ~WM) | (wr_data_i & WM);
      end
      assign stored[g] = q;
    end else begin : g_ro
      assign stored[g] = 8'h00;
    end

    if (g == STRAP_REG) begin : g_strap
      assign rd_vec[g] = stored[g] | {{(8-STRAP_W){1'b0}}, strap_q};
    end else if (g == ID_REG) begin : g_id
      assign rd_vec[g] = stored[g] | ID_BYTE;
    end else begin : g_plain
      assign rd_vec[g] = stored[g];
    end

    assign regs_o[g*8 +: 8] = rd_vec[g];
  end

  assign rd_data_o = (rd_addr_i < 7'(NUM_REGS)) ? rd_vec[rd_addr_i[AW-1:0]] : 8'h00;

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_addr_i < 7'(STRAP_REG))
    |=> regs_o[{$past(wr_addr_i[AW-1:0]), 3'b000} +: 8]
        == ($past(wr_data_i) & reg_wmask(int'($past(wr_addr_i)))));

  a_r8_strap_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_vld_q |=> $stable(strap_q));
endmodule

// File: rtl/clkctl_smbus_slave.sv
module clkctl_smbus_slave
  import clkctl_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] SLV_ADDR    = 7'h69
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [STRAP_W-1:0]    strap_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic [6:0] ptr;
  logic       wr_en;
  logic [7:0] wr_data, rd_data;

  smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  smb_engine #(.SLV_ADDR(SLV_ADDR), .BLK_COUNT(8'(NUM_REGS))) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  clkctl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_i   (strap_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (ptr),
    .wr_data_i (wr_data),
    .rd_addr_i (ptr),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );
endmodule

// File: tb/clkctl_smbus_slave_tb.sv
module clkctl_smbus_slave_tb;
  localparam int H  = 10;
  localparam int NV = 19;
  // {op, offset, value}: op 00 = byte write, 01 = byte read expecting value
  localparam logic [23:0] VEC [NV] = '{
    24'h01_00_FF, 24'h00_00_5A, 24'h01_00_5A, 24'h00_01_FF, 24'h01_01_F7,
    24'h00_03_C3, 24'h01_03_C3, 24'h00_07_00, 24'h01_07_28, 24'h00_06_FF,
    24'h01_06_FD, 24'h00_20_77, 24'h01_20_00, 24'h00_05_81, 24'h01_05_81,
    24'h00_04_3C, 24'h01_04_3C, 24'h00_02_00, 24'h01_02_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  logic [63:0] regs;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkctl_smbus_slave u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .strap_i  (strap),
    .regs_o   (regs)
  );

  task automatic hw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl_m = 1'b0; hw(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(H);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0; hw(2);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H/2);
    ack = !sda_line;
    hw(H/2); scl_m = 1'b0; hw(2);
  endtask

  task automatic recv_byte(bit ack_m, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(H); scl_m = 1'b1; hw(H/2); b[i] = sda_line; hw(H/2); scl_m = 1'b0; hw(2);
    end
    sda_m = !ack_m; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0; hw(2); sda_m = 1'b1;
  endtask

  task automatic wr_byte(logic [6:0] off, logic [7:0] d, output logic [2:0] acks);
    bit a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte({1'b1, off}, a1);
    send_byte(d, a2);
    bus_stop();
    acks = {a0, a1, a2};
  endtask

  task automatic rd_byte(logic [6:0] off, output logic [7:0] d);
    bit a;
    bus_start();
    send_byte(8'hD2, a);
    send_byte({1'b1, off}, a);
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d;
    bit a;
    logic [7:0] blk_exp [8];

    hw(5);
    rst_n = 1'b1;
    hw(5);
    // R1: reset image and released data line
    chk("R1 reset regs", regs, 64'h281D_0007_00FF_F6FF);
    chk("R1 reset drive", {63'b0, sda_oe}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23:16] == 8'h00) begin
        wr_byte(VEC[i][14:8], VEC[i][7:0], acks);
        chk($sformatf("R3 acks vec %0d", i), {61'b0, acks}, 64'h7);
      end else begin
        rd_byte(VEC[i][14:8], d);
        chk($sformatf("R4 read vec %0d", i), {56'b0, d}, {56'b0, VEC[i][7:0]});
      end
    end

    // R7: read-only fields on the parallel view
    chk("R7 byte1 bit3", {56'b0, regs[15:8]}, 64'hF7);
    chk("R7 id byte", {56'b0, regs[63:56]}, 64'h28);

    // R8: strap pins move, captured value stays
    strap = 3'b010;
    hw(20);
    rd_byte(7'd6, d);
    chk("R8 strap held bus", {56'b0, d}, 64'hFD);
    chk("R8 strap held port", {56'b0, regs[55:48]}, 64'hFD);

    // R2: foreign address
    bus_start();
    send_byte(8'hA4, a);
    chk("R2 foreign nack", {63'b0, a}, 64'h0);
    send_byte(8'h80, a);
    send_byte(8'h00, a);
    bus_stop();
    rd_byte(7'd0, d);
    chk("R2 foreign no write", {56'b0, d}, 64'h5A);

    // R9: stop after four data bits
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h83, a);
    send_bits(8'hFF, 4);
    bus_stop();
    chk("R9 partial byte dropped", {56'b0, regs[31:24]}, 64'hC3);

    // R9: repeated start after command restarts the frame
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h85, a);
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h85, a);
    send_byte(8'h99, a);
    bus_stop();
    chk("R9 restart then write", {56'b0, regs[47:40]}, 64'h99);

    // R5: block write of three bytes
    acks = '0;
    bus_start();
    send_byte(8'hD2, a); acks[0] = a;
    send_byte(8'h00, a); acks[1] = a;
    send_byte(8'h03, a); acks[2] = a;
    chk("R5 header acks", {61'b0, acks}, 64'h7);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    chk("R5 data ack", {63'b0, a}, 64'h1);
    bus_stop();
    chk("R5 block bytes", {40'b0, regs[23:0]}, 64'h33_2211);
    chk("R5 offset3 untouched", {56'b0, regs[31:24]}, 64'hC3);

    // R6: block read with leading count
    blk_exp = '{8'h11, 8'h22, 8'h33, 8'hC3, 8'h3C, 8'h99, 8'hFD, 8'h28};
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b1, d);
    chk("R6 count", {56'b0, d}, 64'h08);
    for (int k = 0; k < 8; k++) begin
      recv_byte(k < 7, d);
      chk($sformatf("R6 block byte %0d", k), {56'b0, d}, {56'b0, blk_exp[k]});
    end
    bus_stop();
    chk("R6 released after nack", {63'b0, sda_oe}, 64'h0);

    rd_byte(7'd1, d);
    chk("R4 read after block", {56'b0, d}, 64'h22);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule